// File: doc/BRIEF.md
# UART Interrupt Event Controller

This block turns the activity of a UART's receive and transmit FIFOs, plus a receive-timeout indication, into one interrupt request line. It holds one raw status bit for each of the three events. Each bit has its own set rule and its own automatic clear rule, both driven by the FIFO fill levels and by the per-FIFO read and write strobes. A mask register picks the events that may drive the request. A small register port lets software read the raw status, the mask and the masked status, and clear events by writing ones.

The receive event is level-triggered against a programmable threshold. The transmit event fires only when the transmit level moves down through its threshold. Both events follow simpler single-location rules when the FIFOs are switched off. The timeout event follows a timeout pulse from the receiver and goes away once the receive FIFO drains. The serial shifters, the FIFO storage and the baud timing sit outside this block. They supply the levels, the strobes and the timeout pulse.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when some event has its raw bit set and its mask bit set. After a write of zero to the mask register, `irq` is low from the next cycle on.
- R2: Reading address 2 returns the raw status ANDed with the mask. Reading address 0 returns the raw status whatever the mask holds, with the timeout-bit exception of R9.
- R3: A register write to address 3 clears each event whose data bit is 1. Data bits that are 0 leave their events unchanged. Address 3 reads as zero.
- R4: With `fifo_en` high, the receive bit (bit 0) sets in the cycle after `rx_level` goes from below `rx_trig` to at or above it. It clears in the cycle after `rx_level` is below `rx_trig`. Valid triggers run from 1 to DEPTH.
- R5: With `fifo_en` low, the receive bit sets in the cycle after `rx_level` goes from 0 to nonzero. It clears in the cycle after an `rx_pop` strobe.
- R6: With `fifo_en` high, the transmit bit (bit 1) sets in the cycle after `tx_level` goes from above `tx_trig` to at or below it. A level that has stayed at or below the trigger since reset, or since the last such crossing, sets nothing.
- R7: With `fifo_en` high, the transmit bit clears in the cycle after `tx_level` is above `tx_trig`.
- R8: With `fifo_en` low, the transmit bit is set in every cycle after one in which `tx_level` is 0 and `tx_push` is low. It clears in the cycle after a `tx_push`.
- R9: The timeout bit (bit 2) sets in the cycle after an `rx_timeout` pulse while `rx_level` is nonzero. It clears in the cycle after `rx_level` is 0. It reads as 0 in both status views unless mask bit 2 is set.
- R10: If an event's set condition and a clear write for that event fall in the same cycle, the event ends up set.
- R11: Reset (synchronous, active high) clears all raw bits and all mask bits, so `irq` is low.
- R12: Register map: address 0 holds raw status (read only), address 1 holds the mask (read/write), address 2 holds masked status (read only), address 3 is the clear register (write only). Bit 0 is receive, bit 1 is transmit, bit 2 is timeout. A write takes effect at the clock edge where `reg_wr` is high, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: FIFOs in use; 0: single-location mode |
| rx_level | input | LVLW | Receive FIFO fill level |
| rx_trig | input | LVLW | Receive trigger level |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_level | input | LVLW | Transmit FIFO fill level |
| tx_trig | input | LVLW | Transmit trigger level |
| tx_push | input | 1 | Transmit FIFO write strobe |
| rx_timeout | input | 1 | Receive-timeout pulse from the receiver |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong crossing flag or a wrong event bit shows up at the status port in the very next cycle after the level step that should have set or cleared it. If that bit is unmasked, it shows on `irq` in the same cycle. A stale mask bit shows at once on address 1 and on the masked view. The bench compares all four register views and `irq` against its own model after every clock. A defect therefore shows within one cycle of the first stimulus that exercises it, in directed and in pseudo-random traffic.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NEVT   = 3;
    localparam int EV_RX  = 0;
    localparam int EV_TX  = 1;
    localparam int EV_RTO = 2;

    typedef logic [NEVT-1:0] evt_vec_t;

    typedef enum logic [1:0] {
        ADDR_RAW    = 2'd0,
        ADDR_MASK   = 2'd1,
        ADDR_MASKED = 2'd2,
        ADDR_CLEAR  = 2'd3
    } reg_addr_e;

    // per-event control: a set request, an automatic clear, a software clear
    typedef struct packed {
        logic set;
        logic clr_auto;
        logic clr_wr;
    } evt_ctl_t;

    // set has priority over both clear sources
    function automatic logic evt_next(input logic cur, input evt_ctl_t c);
        if (c.set)
            return 1'b1;
        else if (c.clr_auto || c.clr_wr)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_ctl_t ctl,
    output logic     flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= evt_next(flag, ctl);
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ctl.set |=> flag);

    p_clear_write_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_wr && !ctl.set) |=> !flag);

endmodule

// File: rtl/uart_irq_rx_evt.sv
module uart_irq_rx_evt #(
    parameter int LVLW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_en,
    input  logic [LVLW-1:0] level,
    input  logic [LVLW-1:0] trig,
    input  logic            pop,
    input  logic            clr_wr,
    output logic            raw
);
    import uart_irq_pkg::*;

    logic [LVLW-1:0] thr;
    logic            at_or_above;
    logic            above_q;
    evt_ctl_t        ctl;

    // single-location mode behaves as a threshold of one entry
    assign thr         = fifo_en ? trig : LVLW'(1);
    assign at_or_above = (level >= thr);

    always_ff @(posedge clk) begin
        if (rst)
            above_q <= 1'b0;
        else
            above_q <= at_or_above;
    end

    always_comb begin
        ctl.set      = at_or_above && !above_q;
        ctl.clr_auto = !at_or_above || (!fifo_en && pop);
        ctl.clr_wr   = clr_wr;
    end

    uart_irq_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .flag (raw)
    );

    p_rx_below_r4: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && level < trig) |=> !raw);

    p_rx_pop_r5: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && pop && above_q) |=> !raw);

endmodule

// File: rtl/uart_irq_tx_evt.sv
module uart_irq_tx_evt #(
    parameter int LVLW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_en,
    input  logic [LVLW-1:0] level,
    input  logic [LVLW-1:0] trig,
    input  logic            push,
    input  logic            clr_wr,
    output logic            raw
);
    import uart_irq_pkg::*;

    logic     above_now;
    logic     above_q;
    logic     empty;
    evt_ctl_t ctl;

    assign above_now = (level > trig);
    assign empty     = (level == '0);

    always_ff @(posedge clk) begin
        if (rst)
            above_q <= 1'b0;
        else
            above_q <= above_now;
    end

    always_comb begin
        if (fifo_en) begin
            ctl.set      = above_q && !above_now;
            ctl.clr_auto = above_now;
        end else begin
            ctl.set      = empty && !push;
            ctl.clr_auto = push;
        end
        ctl.clr_wr = clr_wr;
    end

    uart_irq_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .flag (raw)
    );

    p_tx_cross_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(raw) && $past(fifo_en)) |-> ($past(level) <= $past(trig)));

    p_tx_refill_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && level > trig) |=> !raw);

    p_tx_push_r8: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && push) |=> !raw);

endmodule

// File: rtl/uart_irq_rto_evt.sv
module uart_irq_rto_evt #(
    parameter int LVLW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LVLW-1:0] level,
    input  logic            pulse,
    input  logic            clr_wr,
    output logic            raw
);
    import uart_irq_pkg::*;

    logic     drained;
    evt_ctl_t ctl;

    assign drained = (level == '0);

    always_comb begin
        ctl.set      = pulse && !drained;
        ctl.clr_auto = drained;
        ctl.clr_wr   = clr_wr;
    end

    uart_irq_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .flag (raw)
    );

    p_rto_drained_r9: assert property (@(posedge clk) disable iff (rst)
        drained |=> !raw);

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] addr,
    input  evt_vec_t   wdata,
    input  evt_vec_t   raw,
    output evt_vec_t   clr_vec,
    output evt_vec_t   rdata,
    output logic       irq
);

    reg_addr_e sel;
    evt_vec_t  mask_q;
    evt_vec_t  seen;
    evt_vec_t  masked;

    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr && sel == ADDR_MASK)
            mask_q <= wdata;
    end

    assign clr_vec = (wr && sel == ADDR_CLEAR) ? wdata : '0;

    // the timeout bit is hidden from both views unless its mask bit is on
    always_comb begin
        seen         = raw;
        seen[EV_RTO] = raw[EV_RTO] && mask_q[EV_RTO];
    end

    assign masked = seen & mask_q;
    assign irq    = |masked;

    always_comb begin
        case (sel)
            ADDR_RAW:    rdata = seen;
            ADDR_MASK:   rdata = mask_q;
            ADDR_MASKED: rdata = masked;
            default:     rdata = '0;
        endcase
    end

    p_mask_off_r1: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == ADDR_MASK && wdata == '0) |=> !irq);

    p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '0 && !irq));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_en,
    input  logic [LVLW-1:0] rx_level,
    input  logic [LVLW-1:0] rx_trig,
    input  logic            rx_pop,
    input  logic [LVLW-1:0] tx_level,
    input  logic [LVLW-1:0] tx_trig,
    input  logic            tx_push,
    input  logic            rx_timeout,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [2:0]      reg_wdata,
    output logic [2:0]      reg_rdata,
    output logic            irq
);

    evt_vec_t raw;
    evt_vec_t clr_vec;

    uart_irq_rx_evt #(.LVLW(LVLW)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .level   (rx_level),
        .trig    (rx_trig),
        .pop     (rx_pop),
        .clr_wr  (clr_vec[EV_RX]),
        .raw     (raw[EV_RX])
    );

    uart_irq_tx_evt #(.LVLW(LVLW)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .level   (tx_level),
        .trig    (tx_trig),
        .push    (tx_push),
        .clr_wr  (clr_vec[EV_TX]),
        .raw     (raw[EV_TX])
    );

    uart_irq_rto_evt #(.LVLW(LVLW)) u_rto (
        .clk     (clk),
        .rst     (rst),
        .level   (rx_level),
        .pulse   (rx_timeout),
        .clr_wr  (clr_vec[EV_RTO]),
        .raw     (raw[EV_RTO])
    );

    uart_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .raw     (raw),
        .clr_vec (clr_vec),
        .rdata   (reg_rdata),
        .irq     (irq)
    );

endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/10ps
module sim_uart_irq_ctrl;

    localparam int DEPTH = 16;
    localparam int LVLW  = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fifo_en = 1'b1;
    logic [LVLW-1:0] rx_level = '0, rx_trig = LVLW'(4);
    logic [LVLW-1:0] tx_level = '0, tx_trig = LVLW'(4);
    logic            rx_pop = 1'b0, tx_push = 1'b0, rx_timeout = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = 2'd0;
    logic [2:0]      reg_wdata = 3'd0;
    logic [2:0]      reg_rdata;
    logic            irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    bit m_rx, m_tx, m_rto, m_rxa, m_txa;
    bit [2:0] m_mask;

    always #4 clk = ~clk;

    uart_irq_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .rx_level(rx_level), .rx_trig(rx_trig), .rx_pop(rx_pop),
        .tx_level(tx_level), .tx_trig(tx_trig), .tx_push(tx_push),
        .rx_timeout(rx_timeout), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 2'(a);
        #0.2;
        v = int'(reg_rdata);
    endtask

    function automatic bit [2:0] m_view();
        return {m_rto & m_mask[2], m_tx, m_rx};
    endfunction

    // one clock: update the model with the inputs sampled at the edge,
    // drop the strobes, then compare every register view and irq
    task automatic tick();
        bit [2:0] clr;
        bit rx_hit, tx_hi;
        int v;
        @(posedge clk);
        if (rst) begin
            m_rx = 0; m_tx = 0; m_rto = 0; m_rxa = 0; m_txa = 0; m_mask = 0;
        end else begin
            clr    = (reg_wr && reg_addr == 2'd3) ? reg_wdata : 3'b000;
            rx_hit = int'(rx_level) >= (fifo_en ? int'(rx_trig) : 1);
            tx_hi  = int'(tx_level) > int'(tx_trig);
            if (rx_hit && !m_rxa) m_rx = 1;
            else if (!rx_hit || (!fifo_en && rx_pop) || clr[0]) m_rx = 0;
            if (fifo_en) begin
                if (m_txa && !tx_hi) m_tx = 1;
                else if (tx_hi || clr[1]) m_tx = 0;
            end else begin
                if (tx_level == 0 && !tx_push) m_tx = 1;
                else if (tx_push || clr[1]) m_tx = 0;
            end
            if (rx_timeout && rx_level != 0) m_rto = 1;
            else if (rx_level == 0 || clr[2]) m_rto = 0;
            if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata;
            m_rxa = rx_hit;
            m_txa = tx_hi;
        end
        #1;
        reg_wr = 0; rx_pop = 0; tx_push = 0; rx_timeout = 0;
        rd(0, v); check(v, int'(m_view()), "R12 raw view");
        rd(1, v); check(v, int'(m_mask), "R12 mask view");
        rd(2, v); check(v, int'(m_view() & m_mask), "R2 masked view");
        rd(3, v); check(v, 0, "R3 clear reads zero");
        check(int'(irq), int'(|(m_view() & m_mask)), "R1 irq");
    endtask

    task automatic wreg(input int a, input int d);
        reg_wr = 1; reg_addr = 2'(a); reg_wdata = 3'(d);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v;
        tick(); tick();
        rst = 0;
        tick();
        // R11: reset state
        rd(0, v); check(v, 0, "R11 raw after reset");
        rd(1, v); check(v, 0, "R11 mask after reset");
        check(int'(irq), 0, "R11 irq after reset");

        // R4: receive threshold reach and drop
        rx_trig = 4; rx_level = 3; tick();
        rd(0, v); check(v & 1, 0, "R4 below trigger");
        rx_level = 4; tick();
        rd(0, v); check(v & 1, 1, "R4 reached trigger");
        wreg(1, 1); tick();
        check(int'(irq), 1, "R1 masked rx drives irq");
        wreg(3, 0); tick();
        rd(0, v); check(v & 1, 1, "R3 zero write no effect");
        wreg(3, 1); tick();
        rd(0, v); check(v & 1, 0, "R3 clear write");
        rx_level = 3; tick(); rx_level = 4; tick();
        rx_level = 2; tick();
        rd(0, v); check(v & 1, 0, "R4 drop below trigger");

        // R10: set and clear in the same cycle
        rx_level = 4; wreg(3, 1); tick();
        rd(0, v); check(v & 1, 1, "R10 set wins");
        wreg(1, 0); tick();
        check(int'(irq), 0, "R1 mask off");
        rx_level = 0; tick();

        // R6/R7: transmit downward crossing
        tx_trig = 4; tx_level = 2; tick(); tick();
        rd(0, v); check((v >> 1) & 1, 0, "R6 no crossing");
        tx_level = 6; tick();
        tx_level = 4; tick();
        rd(0, v); check((v >> 1) & 1, 1, "R6 crossed downward");
        tx_level = 5; tick();
        rd(0, v); check((v >> 1) & 1, 0, "R7 refill above trigger");

        // R8: single-location transmit
        fifo_en = 0; tx_level = 0; tick();
        rd(0, v); check((v >> 1) & 1, 1, "R8 empty sets");
        tx_push = 1; tick();
        tx_level = 1;
        rd(0, v); check((v >> 1) & 1, 0, "R8 push clears");
        tick();
        rd(0, v); check((v >> 1) & 1, 0, "R8 stays clear while full");

        // R5: single-location receive
        rx_level = 1; tick();
        rd(0, v); check(v & 1, 1, "R5 location filled");
        rx_pop = 1; tick();
        rd(0, v); check(v & 1, 0, "R5 single read clears");
        rx_level = 0; tick();
        fifo_en = 1; tx_level = 8; tick();

        // R9: receive timeout visibility and drain
        rx_trig = 8; rx_level = 2; rx_timeout = 1; tick();
        rd(0, v); check((v >> 2) & 1, 0, "R9 hidden without mask");
        wreg(1, 4); tick();
        rd(0, v); check((v >> 2) & 1, 1, "R9 visible with mask");
        check(int'(irq), 1, "R9 timeout irq");
        rx_level = 0; tick();
        rd(0, v); check((v >> 2) & 1, 0, "R9 drained clears");

        // pseudo-random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 64) == 0) fifo_en = ~fifo_en;
            if (($urandom % 32) == 0) rx_trig = LVLW'(1 + $urandom % DEPTH);
            if (($urandom % 32) == 0) tx_trig = LVLW'(1 + $urandom % DEPTH);
            rx_level = LVLW'($urandom % (DEPTH + 1));
            tx_level = LVLW'($urandom % (DEPTH + 1));
            rx_pop     = ($urandom % 4) == 0;
            tx_push    = ($urandom % 4) == 0;
            rx_timeout = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) wreg($urandom % 4, $urandom % 8);
            tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule